// File: doc/BRIEF.md
# Byte-Port GPIO Bank with Set and Clear Registers

This block is a general-purpose I/O bank for a group of byte-wide ports. Each port has four registers on a simple byte-addressed bus: an output data register, a direction register, a set register that reads back live pin levels, and a clear register whose writes act on the bits given as zero. Firmware can therefore raise or drop single output bits in one bus write, without reading the port first.

By default the bank has eight ports. The first and last implement all eight bits. The six in between implement only bits 3:0; their upper bits read as zero and drop writes. A pin drives its output data bit only while its direction bit is 1. When the direction bit is 0, the pin's level passes through a two-stage synchroniser before it appears on the set register readback. The bus read path is combinational from the address. A write lands on the clock edge where `bus_wr` is sampled high.

Top module: `gpio_bank`

## Requirements
- R1: During and after reset, every output data register and direction register is 0x00, so `pin_out` and `pin_oe` are all zero.
- R2: A write to the output data register of port p (address 0x00+p) stores the byte, and a read of that address returns the stored value, not the pin level.
- R3: A write to the set register of port p (address 0x30+p) sets every output data bit written as 1. Bits written as 0 keep their value.
- R4: A write to the clear register of port p clears every output data bit written as 0. Bits written as 1 keep their value.
- R5: A read of any clear register returns 0x00.
- R6: A read of the set register returns, per bit, the output data bit where the direction bit is 1, and otherwise the `pin_in` level delayed by two clock edges.
- R7: In ports 1 to 6 (4-bit ports), bits 7:4 of every register read as 0 and ignore writes, and the matching `pin_out` and `pin_oe` bits stay 0.
- R8: The clear registers are at 0x52 for port 0, at 0x56 to 0x5B for ports 1 to 6 in order, and at 0x5C for port 7.
- R9: An address that matches no register reads as 0x00, and a write to it changes no register.
- R10: A write to the direction register of port p (address 0x18+p) is read back at that address, and `pin_oe` of that port follows it. A 1 bit means output.
- R11: A write takes effect at the rising clock edge where `bus_wr` is sampled high. Before that edge, the ports show the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PORTS*8 | External pin levels, port p on bits 8p+7:8p |
| pin_out | output | NUM_PORTS*8 | Output data register contents per pin |
| pin_oe | output | NUM_PORTS*8 | Output enable per pin (direction register) |

## Verification
Each output data and direction bit leaves the block through `pin_out` and `pin_oe`. A wrong bit, such as a clear that used the wrong polarity or a set that reached a neighbouring port, is therefore visible at the ports in the cycle after the faulty write, without any read. A decode fault that maps a clear address to the wrong port shows up after the same single edge. A fault in the synchroniser depth or in the direction-based selection affects only the set-register readback. It shows up two edges after a pin change, so the bench samples that readback after one edge and again after two.

// File: rtl/gpio_pkg.sv
// Shared types and address helpers for the GPIO bank.
// Assumes the two full-width ports are the first and last ports of the bank.
package gpio_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // Clear-register address of port idx: wide ends, consecutive narrow middle.
    function automatic byte_t clr_addr(int idx, int nports, byte_t lo_wide,
                                       byte_t narrow_base, byte_t hi_wide);
        if (idx == 0) return lo_wide;
        else if (idx == nports - 1) return hi_wide;
        else return byte_t'(int'(narrow_base) + idx - 1);
    endfunction

    // Mask of implemented bits for a port of the given width.
    function automatic byte_t impl_mask(int width);
        return byte_t'((1 << width) - 1);
    endfunction
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchroniser for external pin levels.
// Assumes STAGES >= 1; all stages reset to 0.
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the sampled levels one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_decode.sv
// Address decoder: one-hot select per port for each register kind.
// Assumes the register windows do not overlap for the configured port count.
module gpio_decode
    import gpio_pkg::*;
#(
    parameter int    NUM_PORTS   = 8,
    parameter byte_t DATA_BASE   = 8'h00,
    parameter byte_t DIR_BASE    = 8'h18,
    parameter byte_t PIN_BASE    = 8'h30,
    parameter byte_t CLR_LO      = 8'h52,
    parameter byte_t CLR_NARROW  = 8'h56,
    parameter byte_t CLR_HI      = 8'h5C
) (
    input  byte_t                addr,
    output logic [NUM_PORTS-1:0] sel_data,
    output logic [NUM_PORTS-1:0] sel_dir,
    output logic [NUM_PORTS-1:0] sel_pin,
    output logic [NUM_PORTS-1:0] sel_clr
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sel
        localparam byte_t A_DATA = byte_t'(int'(DATA_BASE) + p);
        localparam byte_t A_DIR  = byte_t'(int'(DIR_BASE) + p);
        localparam byte_t A_PIN  = byte_t'(int'(PIN_BASE) + p);
        localparam byte_t A_CLR  = clr_addr(p, NUM_PORTS, CLR_LO, CLR_NARROW, CLR_HI);
        assign sel_data[p] = (addr == A_DATA);
        assign sel_dir[p]  = (addr == A_DIR);
        assign sel_pin[p]  = (addr == A_PIN);
        assign sel_clr[p]  = (addr == A_CLR);
    end
endmodule

// File: rtl/gpio_port.sv
// One GPIO port: output data and direction registers, set/clear update,
// pin synchroniser and level readback. Bits above IMPL_W are held at 0.
// Assumes at most one write enable is high per cycle.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int IMPL_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_data,
    input  logic  wr_dir,
    input  logic  wr_set,
    input  logic  wr_clr,
    input  byte_t wdata,
    input  byte_t pin_in,
    output byte_t data_q,
    output byte_t dir_q,
    output byte_t level
);
    localparam byte_t MASK = impl_mask(IMPL_W);

    byte_t pin_sync;

    // Output data register: direct write, set on ones, clear on zeros.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (wr_data) data_q <= wdata & MASK;
        else if (wr_set)  data_q <= data_q | (wdata & MASK);
        else if (wr_clr)  data_q <= data_q & wdata;
    end

    // Direction register: 1 drives the pin.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata & MASK;
    end

    gpio_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_in),
        .q    (pin_sync)
    );

    // Pin level: driven value for outputs, synchronised input otherwise.
    always_comb level = ((data_q & dir_q) | (pin_sync & ~dir_q)) & MASK;
endmodule

// File: rtl/gpio_bank.sv
// GPIO bank top: decodes the byte bus, instantiates one port per byte lane
// and muxes the readback. Reads are combinational; writes land on the edge.
// Assumes WIDE_MASK marks only the first and last ports as full width.
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int                   NUM_PORTS   = 8,
    parameter logic [NUM_PORTS-1:0] WIDE_MASK   = 8'h81,
    parameter int                   NARROW_W    = 4,
    parameter int                   SYNC_STAGES = 2,
    parameter byte_t                DATA_BASE   = 8'h00,
    parameter byte_t                DIR_BASE    = 8'h18,
    parameter byte_t                PIN_BASE    = 8'h30,
    parameter byte_t                CLR_LO      = 8'h52,
    parameter byte_t                CLR_NARROW  = 8'h56,
    parameter byte_t                CLR_HI      = 8'h5C
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [7:0]                  bus_addr,
    input  logic [7:0]                  bus_wdata,
    output logic [7:0]                  bus_rdata,
    input  logic [NUM_PORTS*8-1:0]      pin_in,
    output logic [NUM_PORTS*8-1:0]      pin_out,
    output logic [NUM_PORTS*8-1:0]      pin_oe
);
    logic [NUM_PORTS-1:0] sel_data, sel_dir, sel_pin, sel_clr;
    byte_t data_q [NUM_PORTS];
    byte_t dir_q  [NUM_PORTS];
    byte_t level  [NUM_PORTS];

    gpio_decode #(
        .NUM_PORTS (NUM_PORTS),
        .DATA_BASE (DATA_BASE),
        .DIR_BASE  (DIR_BASE),
        .PIN_BASE  (PIN_BASE),
        .CLR_LO    (CLR_LO),
        .CLR_NARROW(CLR_NARROW),
        .CLR_HI    (CLR_HI)
    ) u_dec (
        .addr    (bus_addr),
        .sel_data(sel_data),
        .sel_dir (sel_dir),
        .sel_pin (sel_pin),
        .sel_clr (sel_clr)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam int IW = WIDE_MASK[p] ? BYTE_W : NARROW_W;
        gpio_port #(.IMPL_W(IW), .SYNC_STAGES(SYNC_STAGES)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_data(bus_wr & sel_data[p]),
            .wr_dir (bus_wr & sel_dir[p]),
            .wr_set (bus_wr & sel_pin[p]),
            .wr_clr (bus_wr & sel_clr[p]),
            .wdata  (bus_wdata),
            .pin_in (pin_in[p*BYTE_W +: BYTE_W]),
            .data_q (data_q[p]),
            .dir_q  (dir_q[p]),
            .level  (level[p])
        );
        assign pin_out[p*BYTE_W +: BYTE_W] = data_q[p];
        assign pin_oe[p*BYTE_W +: BYTE_W]  = dir_q[p];
    end

    // Readback mux; clear registers and unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (sel_data[p]) bus_rdata = data_q[p];
            if (sel_dir[p])  bus_rdata = dir_q[p];
            if (sel_pin[p])  bus_rdata = level[p];
        end
    end
endmodule

// File: rtl/gpio_bank_chk.sv
// Property checker for gpio_bank, attached by bind. Observes ports only.
module gpio_bank_chk
    import gpio_pkg::*;
#(
    parameter int                   NUM_PORTS   = 8,
    parameter logic [NUM_PORTS-1:0] WIDE_MASK   = 8'h81,
    parameter int                   NARROW_W    = 4,
    parameter byte_t                DATA_BASE   = 8'h00,
    parameter byte_t                DIR_BASE    = 8'h18,
    parameter byte_t                PIN_BASE    = 8'h30,
    parameter byte_t                CLR_LO      = 8'h52,
    parameter byte_t                CLR_NARROW  = 8'h56,
    parameter byte_t                CLR_HI      = 8'h5C
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_wr,
    input logic [7:0]             bus_addr,
    input logic [7:0]             bus_wdata,
    input logic [7:0]             bus_rdata,
    input logic [NUM_PORTS*8-1:0] pin_out,
    input logic [NUM_PORTS*8-1:0] pin_oe
);
    // True when the address hits any clear register.
    function automatic logic is_clr(byte_t a);
        for (int p = 0; p < NUM_PORTS; p++)
            if (a == clr_addr(p, NUM_PORTS, CLR_LO, CLR_NARROW, CLR_HI)) return 1'b1;
        return 1'b0;
    endfunction

    // True when the address hits any register at all.
    function automatic logic is_mapped(byte_t a);
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (a == byte_t'(int'(DATA_BASE) + p)) return 1'b1;
            if (a == byte_t'(int'(DIR_BASE) + p))  return 1'b1;
            if (a == byte_t'(int'(PIN_BASE) + p))  return 1'b1;
        end
        return is_clr(a);
    endfunction

    AST_RESET_CLEARS_PINS: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && pin_oe == '0)); // R1

    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        is_clr(bus_addr) |-> bus_rdata == 8'h00); // R5

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !is_mapped(bus_addr) |-> bus_rdata == 8'h00); // R9

    AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !is_mapped(bus_addr)) |=> ($stable(pin_out) && $stable(pin_oe))); // R9

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        localparam byte_t MASK  = impl_mask(WIDE_MASK[p] ? BYTE_W : NARROW_W);
        localparam byte_t A_SET = byte_t'(int'(PIN_BASE) + p);
        localparam byte_t A_CLR = clr_addr(p, NUM_PORTS, CLR_LO, CLR_NARROW, CLR_HI);

        AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == A_SET) |=>
            pin_out[p*BYTE_W +: BYTE_W] ==
                (($past(pin_out[p*BYTE_W +: BYTE_W]) | $past(bus_wdata)) & MASK)); // R3

        AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == A_CLR) |=>
            pin_out[p*BYTE_W +: BYTE_W] ==
                ($past(pin_out[p*BYTE_W +: BYTE_W]) & $past(bus_wdata))); // R4

        if (!WIDE_MASK[p]) begin : g_narrow
            AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (pin_out[p*BYTE_W+BYTE_W-1 : p*BYTE_W+NARROW_W] == '0) &&
                (pin_oe[p*BYTE_W+BYTE_W-1 : p*BYTE_W+NARROW_W] == '0)); // R7
        end
    end
endmodule

bind gpio_bank gpio_bank_chk #(
    .NUM_PORTS (NUM_PORTS),
    .WIDE_MASK (WIDE_MASK),
    .NARROW_W  (NARROW_W),
    .DATA_BASE (DATA_BASE),
    .DIR_BASE  (DIR_BASE),
    .PIN_BASE  (PIN_BASE),
    .CLR_LO    (CLR_LO),
    .CLR_NARROW(CLR_NARROW),
    .CLR_HI    (CLR_HI)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected values, a monitor compares.
module sim_gpio_bank;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = 8'h00;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;
    logic [NP*8-1:0] pin_in = '0;
    logic [NP*8-1:0] pin_out;
    logic [NP*8-1:0] pin_oe;

    gpio_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always #5 clk = ~clk;

    typedef struct { int kind; logic [NP*8-1:0] exp; string tag; } item_t;
    item_t sbq[$];
    event  ev_chk;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;

    logic [7:0] m_data [NP];
    logic [7:0] m_dir  [NP];

    function automatic logic [7:0] msk(int p);
        return (p == 0 || p == NP-1) ? 8'hFF : 8'h0F;
    endfunction
    function automatic logic [7:0] a_clr(int p);
        return (p == 0) ? 8'h52 : (p == NP-1) ? 8'h5C : 8'(8'h55 + p);
    endfunction
    function automatic logic [7:0] lvl(int p, logic [NP*8-1:0] pins);
        return ((m_data[p] & m_dir[p]) | (pins[p*8 +: 8] & ~m_dir[p])) & msk(p);
    endfunction

    // Monitor: pops expected items and compares against the ports.
    initial begin
        forever begin
            @(ev_chk);
            while (sbq.size() > 0) begin
                item_t it;
                logic [NP*8-1:0] act;
                it = sbq.pop_front();
                act = (it.kind == 0) ? {{(NP*8-8){1'b0}}, bus_rdata} :
                      (it.kind == 1) ? pin_out : pin_oe;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic push(int kind, logic [NP*8-1:0] exp, string tag);
        sbq.push_back('{kind, exp, tag});
        -> ev_chk;
        #1;
    endtask

    task automatic expect_rd(logic [7:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        push(0, {{(NP*8-8){1'b0}}, exp}, tag);
    endtask

    task automatic expect_pins(string tag);
        logic [NP*8-1:0] eo, ee;
        for (int p = 0; p < NP; p++) begin
            eo[p*8 +: 8] = m_data[p];
            ee[p*8 +: 8] = m_dir[p];
        end
        @(negedge clk);
        #1;
        push(1, eo, tag);
        push(2, ee, tag);
    endtask

    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_data(int p, logic [7:0] v);
        bus_write(8'(p), v); m_data[p] = v & msk(p);
    endtask
    task automatic wr_dir(int p, logic [7:0] v);
        bus_write(8'(8'h18 + p), v); m_dir[p] = v & msk(p);
    endtask
    task automatic wr_set(int p, logic [7:0] v);
        bus_write(8'(8'h30 + p), v); m_data[p] = m_data[p] | (v & msk(p));
    endtask
    task automatic wr_clr(int p, logic [7:0] v);
        bus_write(a_clr(p), v); m_data[p] = m_data[p] & v;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #1_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int p = 0; p < NP; p++) begin m_data[p] = 8'h00; m_dir[p] = 8'h00; end
        repeat (3) @(negedge clk);
        expect_pins("R1 in reset");
        rst_n = 1'b1;
        expect_pins("R1 after reset");
        for (int p = 0; p < NP; p++) begin
            expect_rd(8'(p), 8'h00, "R1 data");
            expect_rd(8'(8'h18 + p), 8'h00, "R1 dir");
        end

        // R2 and R7: stored value readback, narrow upper bits dropped.
        for (int p = 0; p < NP; p++) begin
            wr_data(p, 8'hF0 | 8'(p));
            expect_rd(8'(p), m_data[p], (msk(p) == 8'hFF) ? "R2" : "R7 narrow write");
            expect_rd(8'(8'h30 + p), 8'h00, "R2 pin level differs from data");
        end
        expect_pins("R2 pins");

        // R10: direction readback and output enable.
        for (int p = 0; p < NP; p++) begin
            wr_dir(p, 8'hA0 | 8'(p + 5));
            expect_rd(8'(8'h18 + p), m_dir[p], "R10 dir");
        end
        expect_pins("R10 oe");

        // R4, R5, R8: clear on zeros at each port's clear address.
        for (int p = 0; p < NP; p++) wr_data(p, 8'hFF);
        for (int p = 0; p < NP; p++) begin
            wr_clr(p, 8'h5A ^ 8'(p << 1));
            expect_rd(8'(p), m_data[p], "R4 R8 clear zeros");
            expect_pins("R8 only target port changed");
            expect_rd(a_clr(p), 8'h00, "R5 clear reads zero");
            wr_clr(p, 8'hFF);
            expect_rd(8'(p), m_data[p], "R4 ones no effect");
        end

        // R3: set on ones, zeros no effect; narrow upper ignored (R7).
        for (int p = 0; p < NP; p++) begin
            wr_set(p, 8'h81);
            expect_rd(8'(p), m_data[p], "R3 set ones");
            wr_set(p, 8'h00);
            expect_rd(8'(p), m_data[p], "R3 zeros no effect");
        end
        wr_data(3, 8'h00);
        wr_set(3, 8'hF0);
        expect_rd(8'h03, 8'h00, "R7 narrow set upper ignored");
        expect_pins("R3 R7 pins");

        // R6: level readback mixes driven and synchronised input bits.
        pin_in = 64'hC3A5_5A3C_9669_F00F;
        repeat (3) @(negedge clk);
        for (int p = 0; p < NP; p++)
            expect_rd(8'(8'h30 + p), lvl(p, pin_in), "R6 level mix");
        begin
            logic [NP*8-1:0] old_pins;
            old_pins = pin_in;
            for (int p = 0; p < NP; p++) wr_dir(p, 8'h00);
            bus_addr = 8'h30;
            @(negedge clk);
            pin_in = ~old_pins;
            expect_rd(8'h30, lvl(0, old_pins), "R6 one edge still old");
            expect_rd(8'h30, lvl(0, ~old_pins), "R6 two edges new");
            expect_rd(8'h37, lvl(7, ~old_pins), "R6 port 7 input");
        end

        // R9: unmapped addresses read zero and ignore writes.
        for (int p = 0; p < NP; p++) wr_data(p, 8'hFF);
        begin
            logic [7:0] holes [4];
            holes = '{8'h40, 8'h55, 8'h5D, 8'hFF};
            foreach (holes[k]) begin
                bus_write(holes[k], 8'h00);
                expect_rd(holes[k], 8'h00, "R9 read zero");
                expect_pins("R9 write ignored");
            end
        end

        // R11: a write shows up only after the sampling edge.
        @(negedge clk);
        bus_addr = 8'h01; bus_wdata = 8'h00; bus_wr = 1'b1;
        #1;
        begin
            logic [NP*8-1:0] eo;
            for (int p = 0; p < NP; p++) eo[p*8 +: 8] = m_data[p];
            push(1, eo, "R11 before edge");
        end
        @(negedge clk);
        bus_wr = 1'b0;
        m_data[1] = 8'h00;
        #1;
        begin
            logic [NP*8-1:0] eo;
            for (int p = 0; p < NP; p++) eo[p*8 +: 8] = m_data[p];
            push(1, eo, "R11 after edge");
        end

        repeat (2) @(negedge clk);
        if (sbq.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard actual=%0d left expected=0", sbq.size());
        end
        finish_run();
    end
endmodule